// File: doc/BRIEF.md
# Four-Phase Traffic Light Sequencer

This block steps a set of three traffic lamps through a fixed four-phase loop: yellow alone, red alone, red together with yellow, green alone, and then yellow alone again. Timing comes from an external 1 Hz square-wave reference. The reference is not fed in as a wave. Instead, a single-cycle enable called the half-period tick is pulsed once every half period. Each phase therefore lasts exactly one half-cycle of the reference.

Inside the block, one register stands in for the level of the reference wave and inverts on every tick. A second register divides that wave by two, flipping whenever the modelled level drops from high to low. The lamps are decoded straight from these two bits. Yellow follows the level. Red follows the divided bit. Green lights only while both bits are low. A 2-bit phase index reports the position in the loop, and a build option selects active-low lamp drive.

Top module: `tl_phase_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, the sequencer is in phase 0. In phase 0 only the yellow lamp is lit.
- R2: Each half-period tick advances the phase by exactly one, in the loop 0, 1, 2, 3, 0. The lamp patterns are: phase 0 yellow only; phase 1 red only; phase 2 red and yellow; phase 3 green only.
- R3: On cycles without a tick, every lamp and the phase index keep their values.
- R4: The yellow lamp is lit exactly while the modelled reference level is high. That level starts high after reset and inverts on every tick.
- R5: The red lamp follows a divided bit. That bit starts low after reset and flips only on ticks where the reference level goes from high to low.
- R6: The green lamp is lit only when both the reference level and the divided bit are low. Green is never lit together with red or yellow.
- R7: The phase index output carries values 0 to 3 in sequence order. At every cycle, exactly one of the four lamp patterns is present.
- R8: A tick sampled at a clock edge is reflected on the lamps and the phase index right after that same edge. The latency is one cycle from the tick being driven, with no additional register stage.
- R9: With the active-low lamp option set, all three lamp outputs are the inverse of the default drive. The phase index is unchanged.
- R10: Reset asserted in any phase returns the block to phase 0 with yellow only, and the loop then continues from phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle enable, once per half period of the 1 Hz reference |
| lamp_red | output | 1 | Red lamp drive |
| lamp_yellow | output | 1 | Yellow lamp drive |
| lamp_green | output | 1 | Green lamp drive |
| phase_idx | output | 2 | Current phase, 0 to 3 in sequence order |

## Verification
All outputs are decoded from two registers. A tick or reset driven before a rising edge therefore shows on the outputs immediately after that edge, one cycle after it was applied. The bench drives stimulus on the falling edge and checks on the next falling edge. At that point the reference model has applied the tick or reset seen at the rising edge between them. Back-to-back ticks, long gaps and reset in each phase are covered. The same expectation is checked against a second instance built with active-low lamps.

// File: rtl/tl_phase_pkg.sv
package tl_phase_pkg;
   localparam int PHASE_W = 2;
   localparam int N_PHASES = 1 << PHASE_W;

   typedef enum logic [PHASE_W-1:0] {
      PH_YEL     = 2'd0,
      PH_RED     = 2'd1,
      PH_RED_YEL = 2'd2,
      PH_GREEN   = 2'd3
   } phase_e;

   typedef struct packed {
      logic red;
      logic yellow;
      logic green;
   } lamp_t;
endpackage

// File: rtl/tl_ref_wave.sv
module tl_ref_wave #(
   parameter bit RESET_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic half_tick,
   output logic level
);
   always_ff @(posedge clk) begin
      if (rst)            level <= RESET_LEVEL;
      else if (half_tick) level <= ~level;
   end

   // R4: the modelled level inverts on each tick
   a_r4_level_flip: assert property (@(posedge clk) disable iff (rst)
      half_tick |=> (level != $past(level)));
   a_r4_level_hold: assert property (@(posedge clk) disable iff (rst)
      !half_tick |=> $stable(level));
endmodule

// File: rtl/tl_halver.sv
module tl_halver (
   input  logic clk,
   input  logic rst,
   input  logic half_tick,
   input  logic level,
   output logic div_q
);
   logic falling;
   assign falling = half_tick & level;

   always_ff @(posedge clk) begin
      if (rst)          div_q <= 1'b0;
      else if (falling) div_q <= ~div_q;
   end

   // R5: divided bit flips only when the level leaves high
   a_r5_div_flip: assert property (@(posedge clk) disable iff (rst)
      (half_tick && level) |=> (div_q != $past(div_q)));
   a_r5_div_hold: assert property (@(posedge clk) disable iff (rst)
      !(half_tick && level) |=> $stable(div_q));
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
   import tl_phase_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               level,
   input  logic               div_q,
   output lamp_t              lamps,
   output logic [PHASE_W-1:0] phase
);
   lamp_t raw;

   always_comb begin
      raw.yellow = level;
      raw.red    = div_q;
      raw.green  = ~level & ~div_q;
   end

   // phase: (1,0)->0, (0,1)->1, (1,1)->2, (0,0)->3
   assign phase = {~(level ^ div_q), ~level};

   generate
      if (ACTIVE_LOW) begin : g_low
         assign lamps = ~raw;
      end else begin : g_high
         assign lamps = raw;
      end
   endgenerate

   // R6: green stands alone
   a_r6_green_alone: assert property (@(posedge clk) disable iff (rst)
      raw.green |-> (!raw.red && !raw.yellow));
   // R7: exactly one of the four patterns
   a_r7_one_pattern: assert property (@(posedge clk) disable iff (rst)
      $onehot({raw.yellow & ~raw.red, raw.red & ~raw.yellow,
               raw.red & raw.yellow, raw.green}));
endmodule

// File: rtl/tl_phase_seq.sv
module tl_phase_seq
   import tl_phase_pkg::*;
#(
   parameter bit LAMP_ACTIVE_LOW = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               half_tick,
   output logic               lamp_red,
   output logic               lamp_yellow,
   output logic               lamp_green,
   output logic [PHASE_W-1:0] phase_idx
);
   generate
      if (N_PHASES != 4) begin : g_bad_cfg
         $error("tl_phase_seq: exactly four phases are supported");
      end
   endgenerate

   logic  level;
   logic  div_q;
   lamp_t lamps;

   tl_ref_wave #(.RESET_LEVEL(1'b1)) u_wave (
      .clk(clk), .rst(rst), .half_tick(half_tick), .level(level));

   tl_halver u_half (
      .clk(clk), .rst(rst), .half_tick(half_tick), .level(level), .div_q(div_q));

   tl_lamp_decode #(.ACTIVE_LOW(LAMP_ACTIVE_LOW)) u_dec (
      .clk(clk), .rst(rst), .level(level), .div_q(div_q),
      .lamps(lamps), .phase(phase_idx));

   assign lamp_red    = lamps.red;
   assign lamp_yellow = lamps.yellow;
   assign lamp_green  = lamps.green;

   // R1 / R10: reset lands in the yellow-only phase
   a_r1_reset_phase: assert property (@(posedge clk)
      rst |=> (phase_idx == PH_YEL));
   // R2: one step per tick
   a_r2_advance: assert property (@(posedge clk) disable iff (rst)
      half_tick |=> (phase_idx == $past(phase_idx) + 2'd1));
   // R3: no tick, no change
   a_r3_hold: assert property (@(posedge clk) disable iff (rst)
      !half_tick |=> $stable({lamp_red, lamp_yellow, lamp_green, phase_idx}));
endmodule

// File: tb/tl_phase_seq_bench.sv
module tl_phase_seq_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic half_tick = 1'b0;
   logic r_hi, y_hi, g_hi, r_lo, y_lo, g_lo;
   logic [1:0] ph_hi, ph_lo;

   int n_tests = 0;
   int n_fail  = 0;
   int exp_phase = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   tl_phase_seq u_tl_phase_seq (
      .clk(clk), .rst(rst), .half_tick(half_tick),
      .lamp_red(r_hi), .lamp_yellow(y_hi), .lamp_green(g_hi), .phase_idx(ph_hi));

   tl_phase_seq #(.LAMP_ACTIVE_LOW(1'b1)) u_tl_phase_seq_low (
      .clk(clk), .rst(rst), .half_tick(half_tick),
      .lamp_red(r_lo), .lamp_yellow(y_lo), .lamp_green(g_lo), .phase_idx(ph_lo));

   // R2 patterns: {red, yellow, green}
   function automatic logic [2:0] lamp_pattern(input int p);
      case (p)
         0: return 3'b010;
         1: return 3'b100;
         2: return 3'b110;
         default: return 3'b001;
      endcase
   endfunction

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b phase_model=%0d", req, act, exp, exp_phase);
      end
   endtask

   // rst/tick applied at negedge, sampled at posedge, checked at next negedge (R8)
   task automatic step(input bit t, input bit r, input string req);
      rst = r;
      half_tick = t;
      @(negedge clk);
      if (r) exp_phase = 0;
      else if (t) exp_phase = (exp_phase + 1) % 4;
      chk(req, {r_hi, y_hi, g_hi, ph_hi}, {lamp_pattern(exp_phase), 2'(exp_phase)});
      // R9: inverted lamps, same phase
      chk("R9", {r_lo, y_lo, g_lo, ph_lo}, {~lamp_pattern(exp_phase), 2'(exp_phase)});
      // R6: green excludes others
      chk("R6", {3'b000, 1'b0, g_hi & (r_hi | y_hi)}, 5'd0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd2718);
      @(negedge clk);
      step(1'b0, 1'b1, "R1");
      step(1'b1, 1'b1, "R1");       // tick ignored under reset
      step(1'b0, 1'b0, "R1");
      // directed full loop, back-to-back ticks
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R2");
      // long gap without ticks
      for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R3");
      // R4/R5: one-tick-then-gap walk, yellow tracks level, red tracks divided bit
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b0, "R4");
         step(1'b0, 1'b0, "R5");
      end
      // R10: reset from each phase
      for (int p = 0; p < 4; p++) begin
         for (int k = 0; k < p; k++) step(1'b1, 1'b0, "R7");
         step(1'b0, 1'b1, "R10");
         step(1'b1, 1'b0, "R10");
         step(1'b0, 1'b1, "R10");
      end
      // random mix
      for (int i = 0; i < 3000; i++) begin
         bit t, r;
         t = ($urandom % 3) == 0;
         r = ($urandom % 97) == 0;
         step(t, r, "R8");
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule